// File: doc/BRIEF.md
# Sectored Direct-Mapped Cache Controller

This block is a direct-mapped, write-back, write-allocate cache in which each line carries one tag. The line is split into subblocks, and every subblock has its own valid bit and its own dirty bit. A processor issues one word-sized read or write at a time over a plain valid/ready request port, and receives a single-cycle response pulse that carries the read word. The write response echoes the stored word.

On the memory side, every transfer moves exactly one subblock. A miss fetches only the subblock that holds the requested word. If the line already carries the right tag, the other subblocks keep their state. If the tag must change, every dirty subblock of the old line is first written back, one transfer each, from the lowest subblock index upwards. Then the new tag is installed and all subblocks of the line start out invalid. The memory port uses a request/acknowledge handshake: the controller holds a request until it is acknowledged, and read data is taken in the cycle the acknowledge is seen.

Top module: `sectored_cache`

## Requirements
- R1: After reset every subblock is invalid, so the first access to any address causes a memory read; after reset req_ready_o is 1 and mem_req_o and resp_valid_o are 0.
- R2: A read that hits a valid subblock with a matching tag returns the stored word with resp_valid_o two cycles after the accepting clock edge, and it makes no memory transfer.
- R3: A miss reads exactly one subblock from memory (mem_we_o=0), at the request address with the subblock offset bits cleared.
- R4: A tag match whose target subblock is invalid fetches only that subblock; the tag and the other subblocks stay valid and still hit.
- R5: Installing a new tag invalidates every other subblock of that line, so a later access to another subblock of the new line misses.
- R6: A write hit updates the word and marks its subblock dirty with no memory transfer; a write miss first fetches the subblock, then merges the word and marks the subblock dirty.
- R7: Before a tag change, each dirty subblock of the old line is written back (mem_we_o=1) exactly once, in ascending subblock order, at the old tag's address, with its current data; clean subblocks are not written.
- R8: Only one request is in flight: req_ready_o is 1 only while idle, it drops after a request is accepted, and resp_valid_o lasts exactly one cycle.
- R9: Once mem_req_o is raised it stays high, with stable mem_we_o, mem_addr_o and write data, until mem_ack_i is seen.
- R10: Byte addresses are word aligned (bits [1:0]=0); with the defaults, bits [3:2] pick the word, bits [5:4] the subblock, bits [7:6] the line, and bits [15:8] form the tag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | CPU request valid |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | Byte address, word aligned |
| req_wdata_i | input | WORD_W | Write word |
| req_ready_o | output | 1 | Controller idle and accepting |
| resp_valid_o | output | 1 | One-cycle response pulse |
| resp_rdata_o | output | WORD_W | Word at the request address |
| mem_req_o | output | 1 | Memory transfer request |
| mem_we_o | output | 1 | 1 = subblock write-back, 0 = subblock fetch |
| mem_addr_o | output | ADDR_W | Subblock-aligned byte address |
| mem_wdata_o | output | SUB_W | Subblock write-back data |
| mem_ack_i | input | 1 | Transfer done; read data valid this cycle |
| mem_rdata_i | input | SUB_W | Fetched subblock data |

## Verification
A stale valid bit shows up as a missing memory read, or as a wrong response word, on the very request that touches the subblock. A lost or extra dirty bit shows up on the next tag change for that line: a write-back is missing, is extra, or comes out of order. A bad tag shows up as a wrong transfer address on the next miss. The bench predicts every memory transfer and every response for each request. A fault is therefore reported within one request of becoming visible, and a dirty-state fault at the next eviction of that line.

// File: rtl/sc_pkg.sv
package sc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_WBACK,
    ST_FILL,
    ST_RESP
  } sc_state_e;
endpackage

// File: rtl/sc_tag_store.sv
module sc_tag_store #(
  parameter int TAG_W     = 8,
  parameter int NUM_LINES = 4,
  parameter int SUBS      = 4
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [$clog2(NUM_LINES)-1:0] idx_i,
  input  logic [$clog2(SUBS)-1:0]      sub_i,
  input  logic                         retag_i,
  input  logic [TAG_W-1:0]             new_tag_i,
  input  logic                         set_valid_i,
  input  logic                         set_dirty_i,
  input  logic                         clr_dirty_i,
  output logic [TAG_W-1:0]             tag_o,
  output logic [SUBS-1:0]              valid_o,
  output logic [SUBS-1:0]              dirty_o
);
  logic [TAG_W-1:0] tag_q   [NUM_LINES];
  logic [SUBS-1:0]  valid_q [NUM_LINES];
  logic [SUBS-1:0]  dirty_q [NUM_LINES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int l = 0; l < NUM_LINES; l++) begin
        tag_q[l]   <= '0;
        valid_q[l] <= '0;
        dirty_q[l] <= '0;
      end
    end else if (retag_i) begin
      // new tag: whole line starts empty
      tag_q[idx_i]   <= new_tag_i;
      valid_q[idx_i] <= '0;
      dirty_q[idx_i] <= '0;
    end else begin
      if (set_valid_i) valid_q[idx_i][sub_i] <= 1'b1;
      if (set_dirty_i)      dirty_q[idx_i][sub_i] <= 1'b1;
      else if (clr_dirty_i) dirty_q[idx_i][sub_i] <= 1'b0;
    end
  end

  assign tag_o   = tag_q[idx_i];
  assign valid_o = valid_q[idx_i];
  assign dirty_o = dirty_q[idx_i];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_chk
    assert_dirty_within_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dirty_q[l] & ~valid_q[l]) == '0);
  end
endmodule

// File: rtl/sc_data_store.sv
module sc_data_store #(
  parameter int WORD_W        = 32,
  parameter int WORDS_PER_SUB = 4,
  parameter int DEPTH         = 16
) (
  input  logic                            clk_i,
  input  logic [$clog2(DEPTH)-1:0]        addr_i,
  input  logic                            wr_en_i,
  input  logic [WORDS_PER_SUB-1:0]        wr_mask_i,
  input  logic [WORD_W*WORDS_PER_SUB-1:0] wr_data_i,
  output logic [WORD_W*WORDS_PER_SUB-1:0] rd_data_o
);
  localparam int SUB_W = WORD_W * WORDS_PER_SUB;

  logic [SUB_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int w = 0; w < WORDS_PER_SUB; w++) begin
        if (wr_mask_i[w]) mem_q[addr_i][w*WORD_W +: WORD_W] <= wr_data_i[w*WORD_W +: WORD_W];
      end
    end
  end

  assign rd_data_o = mem_q[addr_i];
endmodule

// File: rtl/sc_ctrl.sv
module sc_ctrl
  import sc_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int WORD_W        = 32,
  parameter int WORDS_PER_SUB = 4,
  parameter int SUBS          = 4,
  parameter int NUM_LINES     = 4
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic                                   req_valid_i,
  input  logic                                   req_write_i,
  input  logic [ADDR_W-1:0]                      req_addr_i,
  input  logic [WORD_W-1:0]                      req_wdata_i,
  output logic                                   req_ready_o,
  output logic                                   resp_valid_o,
  output logic [WORD_W-1:0]                      resp_rdata_o,
  output logic                                   mem_req_o,
  output logic                                   mem_we_o,
  output logic [ADDR_W-1:0]                      mem_addr_o,
  output logic [WORD_W*WORDS_PER_SUB-1:0]        mem_wdata_o,
  input  logic                                   mem_ack_i,
  input  logic [WORD_W*WORDS_PER_SUB-1:0]        mem_rdata_i,
  output logic [$clog2(NUM_LINES)-1:0]           idx_o,
  output logic [$clog2(SUBS)-1:0]                sub_o,
  output logic                                   retag_o,
  output logic [ADDR_W-$clog2(WORD_W/8)-$clog2(WORDS_PER_SUB)-$clog2(SUBS)-$clog2(NUM_LINES)-1:0] new_tag_o,
  output logic                                   set_valid_o,
  output logic                                   set_dirty_o,
  output logic                                   clr_dirty_o,
  input  logic [ADDR_W-$clog2(WORD_W/8)-$clog2(WORDS_PER_SUB)-$clog2(SUBS)-$clog2(NUM_LINES)-1:0] ts_tag_i,
  input  logic [SUBS-1:0]                        ts_valid_i,
  input  logic [SUBS-1:0]                        ts_dirty_i,
  output logic                                   dat_we_o,
  output logic [WORDS_PER_SUB-1:0]               dat_mask_o,
  output logic [WORD_W*WORDS_PER_SUB-1:0]        dat_wdata_o,
  input  logic [WORD_W*WORDS_PER_SUB-1:0]        dat_rdata_i
);
  localparam int OFF_W  = $clog2(WORD_W/8);
  localparam int WSEL_W = $clog2(WORDS_PER_SUB);
  localparam int SSEL_W = $clog2(SUBS);
  localparam int IDX_W  = $clog2(NUM_LINES);
  localparam int TAG_W  = ADDR_W - OFF_W - WSEL_W - SSEL_W - IDX_W;
  localparam int HI_W   = ADDR_W - OFF_W;

  sc_state_e          state_q;
  logic               wr_q;
  logic [HI_W-1:0]    addr_q;
  logic [WORD_W-1:0]  wdata_q;
  logic [SSEL_W-1:0]  wb_sub_q;

  logic [WSEL_W-1:0]  wsel_r;
  logic [SSEL_W-1:0]  sub_r;
  logic [IDX_W-1:0]   idx_r;
  logic [TAG_W-1:0]   tag_r;
  logic               tag_hit, sub_hit, any_dirty, fill_done, wr_hit;
  logic [SSEL_W-1:0]  low_dirty;
  logic [SUBS-1:0]    lower_mask;

  assign wsel_r = addr_q[0 +: WSEL_W];
  assign sub_r  = addr_q[WSEL_W +: SSEL_W];
  assign idx_r  = addr_q[WSEL_W+SSEL_W +: IDX_W];
  assign tag_r  = addr_q[HI_W-1 -: TAG_W];

  assign tag_hit   = (|ts_valid_i) && (ts_tag_i == tag_r);
  assign sub_hit   = tag_hit && ts_valid_i[sub_r];
  assign any_dirty = |ts_dirty_i;

  always_comb begin
    logic found;
    low_dirty = '0;
    found     = 1'b0;
    for (int s = 0; s < SUBS; s++) begin
      if (ts_dirty_i[s] && !found) begin
        low_dirty = SSEL_W'(s);
        found     = 1'b1;
      end
    end
  end

  always_comb begin
    for (int s = 0; s < SUBS; s++) lower_mask[s] = SSEL_W'(s) < wb_sub_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      wr_q     <= 1'b0;
      addr_q   <= '0;
      wdata_q  <= '0;
      wb_sub_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          wr_q    <= req_write_i;
          addr_q  <= req_addr_i[ADDR_W-1:OFF_W];
          wdata_q <= req_wdata_i;
          state_q <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (sub_hit)        state_q <= ST_RESP;
          else if (tag_hit)   state_q <= ST_FILL;
          else if (any_dirty) begin
            wb_sub_q <= low_dirty;
            state_q  <= ST_WBACK;
          end else            state_q <= ST_FILL;
        end
        ST_WBACK: if (mem_ack_i) state_q <= ST_LOOKUP;  // re-evaluate for next dirty subblock
        ST_FILL:  if (mem_ack_i) state_q <= ST_RESP;
        ST_RESP:  state_q <= ST_IDLE;
        default:  state_q <= ST_IDLE;
      endcase
    end
  end

  assign fill_done = (state_q == ST_FILL) && mem_ack_i;
  assign wr_hit    = (state_q == ST_LOOKUP) && sub_hit && wr_q;

  assign idx_o       = idx_r;
  assign sub_o       = (state_q == ST_WBACK) ? wb_sub_q : sub_r;
  assign retag_o     = (state_q == ST_LOOKUP) && !tag_hit && !any_dirty;
  assign new_tag_o   = tag_r;
  assign set_valid_o = fill_done;
  assign set_dirty_o = wr_hit || (fill_done && wr_q);
  assign clr_dirty_o = (state_q == ST_WBACK) && mem_ack_i;

  assign dat_we_o   = fill_done || wr_hit;
  assign dat_mask_o = fill_done ? '1 : (WORDS_PER_SUB'(1) << wsel_r);
  for (genvar w = 0; w < WORDS_PER_SUB; w++) begin : g_merge
    assign dat_wdata_o[w*WORD_W +: WORD_W] =
      (wr_q && wsel_r == WSEL_W'(w)) ? wdata_q : mem_rdata_i[w*WORD_W +: WORD_W];
  end

  assign req_ready_o  = (state_q == ST_IDLE);
  assign resp_valid_o = (state_q == ST_RESP);
  assign resp_rdata_o = dat_rdata_i[wsel_r*WORD_W +: WORD_W];
  assign mem_req_o    = (state_q == ST_WBACK) || (state_q == ST_FILL);
  assign mem_we_o     = (state_q == ST_WBACK);
  assign mem_addr_o   = (state_q == ST_WBACK)
                      ? {ts_tag_i, idx_r, wb_sub_q, {(OFF_W+WSEL_W){1'b0}}}
                      : {tag_r, idx_r, sub_r, {(OFF_W+WSEL_W){1'b0}}};
  assign mem_wdata_o  = dat_rdata_i;

  assert_aligned_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |-> req_addr_i[OFF_W-1:0] == '0);
  assert_one_in_flight_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> !req_ready_o);
  assert_resp_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
  assert_mem_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o));
  assert_wdata_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !mem_ack_i) |=> $stable(mem_wdata_o));
  assert_wb_dirty_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WBACK) |-> ts_dirty_i[wb_sub_q]);
  assert_wb_order_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WBACK) |-> (ts_dirty_i & lower_mask) == '0);
  assert_fill_target_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_FILL) |-> (ts_tag_i == tag_r) && !ts_valid_i[sub_r]);
  assert_retag_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retag_o |=> (ts_valid_i == '0) && (ts_dirty_i == '0));
endmodule

// File: rtl/sectored_cache.sv
module sectored_cache #(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int SUB_BYTES  = 16,
  parameter int LINE_BYTES = 64,
  parameter int NUM_LINES  = 4,
  localparam int SUB_W     = SUB_BYTES * 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              req_ready_o,
  output logic              resp_valid_o,
  output logic [WORD_W-1:0] resp_rdata_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [SUB_W-1:0]  mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [SUB_W-1:0]  mem_rdata_i
);
  localparam int WORDS_PER_SUB = SUB_BYTES / (WORD_W/8);
  localparam int SUBS          = LINE_BYTES / SUB_BYTES;
  localparam int SSEL_W        = $clog2(SUBS);
  localparam int IDX_W         = $clog2(NUM_LINES);
  localparam int TAG_W         = ADDR_W - $clog2(LINE_BYTES) - IDX_W;

  logic [IDX_W-1:0]         idx;
  logic [SSEL_W-1:0]        sub;
  logic                     retag, set_valid, set_dirty, clr_dirty, dat_we;
  logic [TAG_W-1:0]         new_tag, ts_tag;
  logic [SUBS-1:0]          ts_valid, ts_dirty;
  logic [WORDS_PER_SUB-1:0] dat_mask;
  logic [SUB_W-1:0]         dat_wdata, dat_rdata;

  sc_ctrl #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .WORDS_PER_SUB(WORDS_PER_SUB),
    .SUBS(SUBS), .NUM_LINES(NUM_LINES)
  ) u_ctrl (
    .clk_i, .rst_ni, .req_valid_i, .req_write_i, .req_addr_i, .req_wdata_i,
    .req_ready_o, .resp_valid_o, .resp_rdata_o,
    .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o, .mem_ack_i, .mem_rdata_i,
    .idx_o(idx), .sub_o(sub), .retag_o(retag), .new_tag_o(new_tag),
    .set_valid_o(set_valid), .set_dirty_o(set_dirty), .clr_dirty_o(clr_dirty),
    .ts_tag_i(ts_tag), .ts_valid_i(ts_valid), .ts_dirty_i(ts_dirty),
    .dat_we_o(dat_we), .dat_mask_o(dat_mask), .dat_wdata_o(dat_wdata), .dat_rdata_i(dat_rdata)
  );

  sc_tag_store #(.TAG_W(TAG_W), .NUM_LINES(NUM_LINES), .SUBS(SUBS)) u_tags (
    .clk_i, .rst_ni, .idx_i(idx), .sub_i(sub), .retag_i(retag), .new_tag_i(new_tag),
    .set_valid_i(set_valid), .set_dirty_i(set_dirty), .clr_dirty_i(clr_dirty),
    .tag_o(ts_tag), .valid_o(ts_valid), .dirty_o(ts_dirty)
  );

  sc_data_store #(.WORD_W(WORD_W), .WORDS_PER_SUB(WORDS_PER_SUB), .DEPTH(NUM_LINES*SUBS)) u_data (
    .clk_i, .addr_i({idx, sub}), .wr_en_i(dat_we), .wr_mask_i(dat_mask),
    .wr_data_i(dat_wdata), .rd_data_o(dat_rdata)
  );
endmodule

// File: tb/tb_sectored_cache.sv
module tb_sectored_cache;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [15:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         req_ready, resp_valid;
  logic [31:0]  resp_rdata;
  logic         mem_req, mem_we;
  logic [15:0]  mem_addr;
  logic [127:0] mem_wdata;
  logic         mem_ack = 1'b0;
  logic [127:0] mem_rdata = '0;

  always #10 clk = ~clk;

  sectored_cache dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
    .resp_valid_o(resp_valid), .resp_rdata_o(resp_rdata),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  int total = 0, bad = 0, wcnt = 0;

  typedef struct { bit we; logic [15:0] addr; logic [127:0] data; } mop_t;
  mop_t exp_q[$];
  logic [31:0] bmem [int];

  // reference cache state
  logic [7:0]  m_tag [4];
  logic [3:0]  m_val [4];
  logic [3:0]  m_dir [4];
  logic [31:0] m_dat [4][4][4];

  function automatic logic [31:0] bm_rd(int a);
    if (bmem.exists(a)) return bmem[a];
    return (32'(a) * 32'h0000_9E37) ^ 32'h5A5A_0000;
  endfunction

  task automatic chk(input string rq, input string what, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h", rq, what, act, exp);
    end
  endtask

  // memory responder: acknowledges two cycles after a request appears
  always @(negedge clk) begin
    if (!rst_n) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_ack) begin
      mem_ack = 1'b0;
      wcnt = 0;
    end else if (mem_req) begin
      wcnt++;
      if (wcnt == 2) begin
        if (exp_q.size() == 0) begin
          chk("R3", "unexpected transfer addr", {112'd0, mem_addr}, 128'hFFFF_FFFF);
        end else begin
          mop_t e;
          e = exp_q.pop_front();
          chk(e.we ? "R7" : "R3", "mem_we", {127'd0, mem_we}, {127'd0, e.we});
          chk(e.we ? "R7" : "R3", "mem_addr", {112'd0, mem_addr}, {112'd0, e.addr});
          if (e.we) chk("R7", "mem_wdata", mem_wdata, e.data);
        end
        if (mem_we) begin
          for (int k = 0; k < 4; k++) bmem[int'(mem_addr) + 4*k] = mem_wdata[k*32 +: 32];
        end else begin
          for (int k = 0; k < 4; k++) mem_rdata[k*32 +: 32] = bm_rd(int'(mem_addr) + 4*k);
        end
        mem_ack = 1'b1;
      end
    end
  end

  task automatic do_req(input string rq, input bit wr, input logic [15:0] a, input logic [31:0] d);
    logic [1:0] idx, sub, w;
    logic [7:0] tg;
    logic [15:0] base;
    logic [31:0] expd;
    bit hit;
    int cyc;
    idx = a[7:6]; sub = a[5:4]; w = a[3:2]; tg = a[15:8];
    hit = (|m_val[idx]) && (m_tag[idx] == tg) && m_val[idx][sub];
    if (!((|m_val[idx]) && (m_tag[idx] == tg))) begin
      for (int s = 0; s < 4; s++) begin
        if (m_dir[idx][s]) begin
          mop_t e;
          e.we = 1'b1;
          e.addr = {m_tag[idx], idx, 2'(s), 4'b0};
          e.data = {m_dat[idx][s][3], m_dat[idx][s][2], m_dat[idx][s][1], m_dat[idx][s][0]};
          exp_q.push_back(e);
        end
      end
      m_val[idx] = '0; m_dir[idx] = '0; m_tag[idx] = tg;
    end
    if (!m_val[idx][sub]) begin
      mop_t e;
      base = {tg, idx, sub, 4'b0};
      e.we = 1'b0; e.addr = base; e.data = '0;
      exp_q.push_back(e);
      for (int k = 0; k < 4; k++) m_dat[idx][sub][k] = bm_rd(int'(base) + 4*k);
      m_val[idx][sub] = 1'b1;
    end
    if (wr) begin
      m_dat[idx][sub][w] = d;
      m_dir[idx][sub] = 1'b1;
    end
    expd = m_dat[idx][sub][w];

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R8", "ready while busy", {127'd0, req_ready}, 128'd0);
    cyc = 1;
    while (!resp_valid && cyc < 100) begin
      @(negedge clk);
      cyc++;
    end
    if (cyc >= 100) chk(rq, "response timeout", 128'd0, 128'd1);
    chk(rq, "resp_rdata", {96'd0, resp_rdata}, {96'd0, expd});
    if (hit) chk("R2", "hit latency", 128'(cyc), 128'd2);
    chk(rq, "pending transfers", 128'(exp_q.size()), 128'd0);
    exp_q.delete();
    @(negedge clk);
    chk("R8", "resp pulse width", {127'd0, resp_valid}, 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int l = 0; l < 4; l++) begin m_val[l] = '0; m_dir[l] = '0; m_tag[l] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", {127'd0, req_ready}, 128'd1);
    chk("R1", "mem_req after reset", {127'd0, mem_req}, 128'd0);
    chk("R1", "resp after reset", {127'd0, resp_valid}, 128'd0);

    do_req("R1", 1'b0, 16'h0000, 32'd0);             // cold miss
    do_req("R2", 1'b0, 16'h0004, 32'd0);             // hit
    do_req("R4", 1'b0, 16'h0010, 32'd0);             // subblock miss, same tag
    do_req("R4", 1'b0, 16'h0000, 32'd0);             // earlier subblock still hits
    do_req("R6", 1'b1, 16'h0008, 32'hCAFE_0001);     // write hit
    do_req("R6", 1'b1, 16'h0034, 32'hBEEF_0003);     // write miss, allocate
    do_req("R6", 1'b0, 16'h0034, 32'd0);             // read back merged word
    do_req("R7", 1'b0, 16'h0100, 32'd0);             // evict: write back sub0 then sub3
    do_req("R5", 1'b0, 16'h0110, 32'd0);             // other subblock of new tag misses
    do_req("R10", 1'b0, 16'h0008, 32'd0);            // old data returns from memory
    do_req("R3", 1'b0, 16'h00C0, 32'd0);             // line 3
    do_req("R10", 1'b1, 16'hFFFC, 32'h1234_5678);    // top tag, line 3, sub 3
    do_req("R7", 1'b0, 16'h00F0, 32'd0);             // evict dirty top line

    lfsr = 16'hACE1;
    for (int i = 0; i < 80; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      do_req("R7", lfsr[0], {6'd0, lfsr[10:3], 2'b00}, {lfsr, ~lfsr});
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule